// File: doc/BRIEF.md
# Bitstream Health and Clip Monitor

This block sits on the receiving side of a 1-bit delta-sigma link and watches the raw bit stream before any decimation filter. It measures runs of equal bits and sorts the stream into four states: ordinary modulation, positive full-scale clipping, negative full-scale clipping, and a failed source. A failed source holds the line at a steady logic 1. A clipped source instead sends one bit of opposite value after every 127 equal bits, so each period is 128 bits long. The monitor tells these two apart by the length of the runs it sees.

Bits are offered on `bit_in` and qualified by `bit_en`. Only qualified bits count. The monitor reports a 2-bit status code and pulses `status_vld` for one cycle whenever that code changes. Its verdict depends only on run lengths that have already finished, except for the failure check. That check fires while the long run of ones is still in progress.

Top module: `bitstream_health_mon`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `status` is 2'b00 and `status_vld` is 0. The run tracking restarts from nothing after reset.
- R2: Status encoding is 2'b00 normal, 2'b01 positive clip, 2'b10 negative clip and 2'b11 fault. Status becomes 2'b11 on the clock edge that accepts the 256th consecutive accepted 1. After 255 consecutive ones, status is not yet 2'b11.
- R3: A run of exactly 127 ones ended by a 0 counts as one positive clip period. When two such periods occur in a row, separated only by their single 0 bit, status becomes 2'b01 on the edge that accepts the second terminating 0.
- R4: A run of exactly 127 zeros ended by a 1 counts as one negative clip period. Two such periods in a row set status to 2'b10 on the edge that accepts the second terminating 1.
- R5: A single clip period on its own leaves the status unchanged.
- R6: When a run shorter than 120 bits ends, status returns to 2'b00 (a run of 119 does this). The exception is a run of exactly one bit that directly follows a run of 120 bits or more: that single bit is a clip marker and is neutral.
- R7: When a run of 120 to 126 bits ends, or a run of 128 bits or more ends, status is held. Any partial clip-period progress is discarded, so a later clip period counts as the first again.
- R8: Cycles with `bit_en` low are ignored. They change neither the status nor any run length, and they raise no `status_vld`.
- R9: `status_vld` is high for exactly one cycle, in the first cycle that shows a new status value, and never otherwise.
- R10: While status is a clip code, further matching clip periods keep the code and raise no `status_vld`.
- R11: A fault is left only through a later short run (R6) or a confirmed clip (R3/R4). The run of ones that caused the fault ending by itself keeps status at 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Sampled modulator bit |
| status | output | 2 | 00 normal, 01 positive clip, 10 negative clip, 11 fault |
| status_vld | output | 1 | One-cycle pulse when `status` takes a new value |

## Verification
The bench builds the monitor with its default parameters: a 128-bit clip period, two periods to confirm, a 256-one fault threshold and a 120-bit short-run bound. These are the real thresholds, so every boundary can be reached in a few thousand bits. The boundaries exercised are a 119 versus 120 bit run, a 127 versus 128 bit run, and 255 versus 256 ones. One continuous stream carries the bench through confirmation, hold, discard of clip progress and fault release. Directed tests then cover gated input and a reset taken while in fault.

// File: rtl/bhm_pkg.sv
package bhm_pkg;

   typedef enum logic [1:0] {
      ST_NORMAL = 2'b00,
      ST_POS    = 2'b01,
      ST_NEG    = 2'b10,
      ST_FAULT  = 2'b11
   } bhm_status_e;

   // what a finished run means to the status logic
   typedef enum logic [2:0] {
      EV_NONE  = 3'd0,
      EV_SHORT = 3'd1,
      EV_CLIP  = 3'd2,
      EV_MARK  = 3'd3,
      EV_HOLD  = 3'd4
   } bhm_event_e;

endpackage

// File: rtl/bhm_run_tracker.sv
module bhm_run_tracker #(
   parameter int FAULT_LEN = 256,
   parameter int LONG_MIN  = 120,
   parameter int LEN_W     = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             bit_in,
   output logic             run_end,
   output logic [LEN_W-1:0] end_len,
   output logic             end_val,
   output logic             prev_long,
   output logic             fault_hit
);

   localparam logic [LEN_W-1:0] SAT_LEN  = LEN_W'(FAULT_LEN);
   localparam logic [LEN_W-1:0] HIT_LEN  = LEN_W'(FAULT_LEN - 1);
   localparam logic [LEN_W-1:0] LONG_LEN = LEN_W'(LONG_MIN);

   logic             have_q;
   logic             last_q;
   logic             long_q;
   logic [LEN_W-1:0] len_q;
   logic             same_bit;

   assign same_bit  = have_q && (bit_in == last_q);
   assign run_end   = bit_en && have_q && (bit_in != last_q);
   assign fault_hit = bit_en && same_bit && bit_in && (len_q == HIT_LEN);
   assign end_len   = len_q;
   assign end_val   = last_q;
   assign prev_long = long_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_q <= 1'b0;
         last_q <= 1'b0;
         long_q <= 1'b0;
         len_q  <= '0;
      end else if (bit_en) begin
         have_q <= 1'b1;
         last_q <= bit_in;
         if (run_end) begin
            len_q  <= LEN_W'(1);
            long_q <= (len_q >= LONG_LEN);
         end else if (!have_q) begin
            len_q  <= LEN_W'(1);
         end else if (len_q != SAT_LEN) begin
            len_q  <= len_q + LEN_W'(1);
         end
      end
   end

endmodule

// File: rtl/bhm_run_classifier.sv
module bhm_run_classifier
   import bhm_pkg::*;
#(
   parameter int CLIP_RUN   = 127,
   parameter int NORMAL_MAX = 120,
   parameter int LEN_W      = 9
) (
   input  logic             run_end,
   input  logic [LEN_W-1:0] end_len,
   input  logic             prev_long,
   output bhm_event_e       kind
);

   localparam logic [LEN_W-1:0] CLIP_LEN  = LEN_W'(CLIP_RUN);
   localparam logic [LEN_W-1:0] SHORT_LIM = LEN_W'(NORMAL_MAX);
   localparam logic [LEN_W-1:0] ONE_LEN   = LEN_W'(1);

   always_comb begin
      if (!run_end)
         kind = EV_NONE;
      else if (end_len == CLIP_LEN)
         kind = EV_CLIP;
      else if (end_len == ONE_LEN && prev_long)
         kind = EV_MARK;
      else if (end_len < SHORT_LIM)
         kind = EV_SHORT;
      else
         kind = EV_HOLD;
   end

endmodule

// File: rtl/bhm_clip_confirm.sv
module bhm_clip_confirm
   import bhm_pkg::*;
#(
   parameter int CONFIRM = 2,
   parameter int CNT_W   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  bhm_event_e kind,
   input  logic       end_val,
   output logic       clip_hit,
   output logic       hit_pos
);

   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CONFIRM);

   logic [CNT_W-1:0] cnt_q;
   logic             pol_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             pol_nxt;

   always_comb begin
      cnt_nxt = cnt_q;
      pol_nxt = pol_q;
      case (kind)
         EV_CLIP: begin
            if (cnt_q != '0 && pol_q == end_val)
               cnt_nxt = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(1);
            else
               cnt_nxt = CNT_W'(1);
            pol_nxt = end_val;
         end
         EV_SHORT, EV_HOLD: cnt_nxt = '0;
         default: ;
      endcase
   end

   assign clip_hit = (kind == EV_CLIP) && (cnt_nxt >= CNT_MAX);
   assign hit_pos  = end_val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pol_q <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         pol_q <= pol_nxt;
      end
   end

endmodule

// File: rtl/bhm_status_fsm.sv
module bhm_status_fsm
   import bhm_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        fault_hit,
   input  logic        clip_hit,
   input  logic        hit_pos,
   input  bhm_event_e  kind,
   output bhm_status_e status,
   output logic        status_vld
);

   bhm_status_e st_q;
   bhm_status_e st_nxt;
   logic        vld_q;

   always_comb begin
      st_nxt = st_q;
      if (fault_hit)
         st_nxt = ST_FAULT;
      else if (clip_hit)
         st_nxt = hit_pos ? ST_POS : ST_NEG;
      else if (kind == EV_SHORT)
         st_nxt = ST_NORMAL;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_NORMAL;
         vld_q <= 1'b0;
      end else begin
         st_q  <= st_nxt;
         vld_q <= (st_nxt != st_q);
      end
   end

   assign status     = st_q;
   assign status_vld = vld_q;

endmodule

// File: rtl/bitstream_health_mon.sv
module bitstream_health_mon
   import bhm_pkg::*;
#(
   parameter int PERIOD     = 128,
   parameter int CONFIRM    = 2,
   parameter int FAULT_LEN  = 256,
   parameter int NORMAL_MAX = 120
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic       bit_in,
   output logic [1:0] status,
   output logic       status_vld
);

   localparam int CLIP_RUN = PERIOD - 1;
   localparam int LEN_W    = $clog2(FAULT_LEN + 1);
   localparam int CNT_W    = $clog2(CONFIRM + 1);

   if (CONFIRM < 1) begin : g_bad_confirm
      $error("CONFIRM must be at least 1");
   end
   if (NORMAL_MAX < 2 || NORMAL_MAX > CLIP_RUN) begin : g_bad_short
      $error("NORMAL_MAX must lie in 2..PERIOD-1");
   end
   if (FAULT_LEN <= PERIOD) begin : g_bad_fault
      $error("FAULT_LEN must exceed PERIOD");
   end

   logic             run_end;
   logic [LEN_W-1:0] end_len;
   logic             end_val;
   logic             prev_long;
   logic             fault_hit;
   logic             clip_hit;
   logic             hit_pos;
   bhm_event_e       kind;
   bhm_status_e      st;

   bhm_run_tracker #(
      .FAULT_LEN (FAULT_LEN),
      .LONG_MIN  (NORMAL_MAX),
      .LEN_W     (LEN_W)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .bit_in    (bit_in),
      .run_end   (run_end),
      .end_len   (end_len),
      .end_val   (end_val),
      .prev_long (prev_long),
      .fault_hit (fault_hit)
   );

   bhm_run_classifier #(
      .CLIP_RUN   (CLIP_RUN),
      .NORMAL_MAX (NORMAL_MAX),
      .LEN_W      (LEN_W)
   ) u_class (
      .run_end   (run_end),
      .end_len   (end_len),
      .prev_long (prev_long),
      .kind      (kind)
   );

   bhm_clip_confirm #(
      .CONFIRM (CONFIRM),
      .CNT_W   (CNT_W)
   ) u_clip (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind     (kind),
      .end_val  (end_val),
      .clip_hit (clip_hit),
      .hit_pos  (hit_pos)
   );

   bhm_status_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .fault_hit  (fault_hit),
      .clip_hit   (clip_hit),
      .hit_pos    (hit_pos),
      .kind       (kind),
      .status     (st),
      .status_vld (status_vld)
   );

   assign status = st;

endmodule

// File: rtl/bhm_chk.sv
module bhm_chk #(
   parameter int FAULT_LEN = 256
) (
   input logic       clk,
   input logic       rst_n,
   input logic       bit_en,
   input logic       bit_in,
   input logic [1:0] status,
   input logic       status_vld
);

   logic [15:0] ones_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ones_q <= '0;
      else if (bit_en)
         ones_q <= !bit_in ? 16'd0 : (ones_q == 16'hFFFF ? ones_q : ones_q + 16'd1);
   end

   // R9
   vld_means_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_vld |-> (status != $past(status)));

   // R9
   change_flags_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status != $past(status)) |-> status_vld);

   // R8
   idle_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bit_en) |-> ($stable(status) && !status_vld));

   // R2
   fault_needs_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 2'b11 && $past(status) != 2'b11) |->
         ($past(bit_en) && $past(bit_in) && $past(ones_q) >= 16'(FAULT_LEN - 1)));

   // R3
   pos_entry_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 2'b01 && $past(status) != 2'b01) |-> ($past(bit_en) && !$past(bit_in)));

   // R4
   neg_entry_on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 2'b10 && $past(status) != 2'b10) |-> ($past(bit_en) && $past(bit_in)));

endmodule

bind bitstream_health_mon bhm_chk #(.FAULT_LEN(FAULT_LEN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bit_en     (bit_en),
   .bit_in     (bit_in),
   .status     (status),
   .status_vld (status_vld)
);

// File: tb/sim_bitstream_health_mon.sv
`timescale 1ns/1ps
module sim_bitstream_health_mon;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       bit_in = 1'b0;
   logic [1:0] status;
   logic       status_vld;

   int errors = 0;
   int checks = 0;
   int vld_seen = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   bitstream_health_mon u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .bit_in     (bit_in),
      .status     (status),
      .status_vld (status_vld)
   );

   localparam int NSEG = 33;
   // one continuous stream: bit value, run length, status expected afterwards
   localparam int SEG_VAL [NSEG] = '{1,0,1,0,1,0,1,0,1,0, 1,0,1,0,1,0,1,0,1,0,
                                     1,0,1,0,1,0,1,0,1,1, 1,0,1};
   localparam int SEG_LEN [NSEG] = '{10,10,127,1,127,1,127,1,50,50,
                                     5,127,1,127,1,127,1,120,1,119,
                                     127,1,128,1,127,1,127,1,255,1,
                                     10,5,1};
   localparam int SEG_EXP [NSEG] = '{0,0,0,0,0,1,1,1,1,0,
                                     0,0,0,0,2,2,2,2,2,2,
                                     0,0,0,0,0,0,0,1,1,3,
                                     3,3,0};

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive len bits of value v; vld pulses are counted at each negedge
   task automatic send_run(input int v, input int len);
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         if (status_vld) vld_seen++;
         bit_en = 1'b1;
         bit_in = v[0];
      end
      @(negedge clk);
      if (status_vld) vld_seen++;
      bit_en = 1'b0;
   endtask

   function automatic string seg_req(input int i);
      case (i)
         3:  return "R5";
         5:  return "R3";
         7:  return "R10";
         9:  return "R6";
         14: return "R4";
         18: return "R7";
         20: return "R6";
         25: return "R7";
         27: return "R3";
         28: return "R2";
         29: return "R2";
         31: return "R11";
         32: return "R11";
         default: return "R9";
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      int prev_exp;
      repeat (4) @(negedge clk);
      check("R1", status, 0);
      check("R1", status_vld, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", status, 0);
      check("R1", status_vld, 0);

      prev_exp = 0;
      for (int i = 0; i < NSEG; i++) begin
         vld_seen = 0;
         send_run(SEG_VAL[i], SEG_LEN[i]);
         check(seg_req(i), status, SEG_EXP[i]);
         check("R9", vld_seen, (SEG_EXP[i] != prev_exp) ? 1 : 0);
         prev_exp = SEG_EXP[i];
      end

      // R8: ungated ones with bit_en low do nothing
      vld_seen = 0;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (status_vld) vld_seen++;
         bit_en = 1'b0;
         bit_in = 1'b1;
      end
      check("R8", status, 0);
      check("R8", vld_seen, 0);

      // R2 from a fresh run: 255 ones not yet fault, 256th is
      send_run(0, 1);
      send_run(1, 255);
      check("R2", status, 0);
      send_run(1, 1);
      check("R2", status, 3);

      // R1: reset while in fault
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1", status, 0);
      check("R1", status_vld, 0);
      rst_n = 1'b1;
      send_run(1, 200);
      check("R1", status, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule